// File: doc/BRIEF.md
# Bottom Row Merging Stage Controller

This block controls one stage of the collection row at the bottom of a two-dimensional FIFO array. Each stage holds at most one item. It takes that item either from the column FIFO directly above it or from its neighbour on the left, and it passes the item on to the stage on its right. Data is handed over with a valid/ready handshake on every port. Two valid/ready inputs (up and left) and one valid/ready output connect the stage.

Items that started in the leftmost stage of the row carry a one-bit origin tag. The stage uses only that tag to decide where its next item comes from:
- The first item after reset comes from above.
- After a tagged item has left, the next item comes from above.
- After an untagged item has left, the next item comes from the left.

This keeps the items of the whole row in order without any counter. Internally the control is a four-state machine: empty expecting above, full with an untagged item, empty expecting left, and full with a tagged item.

The port that the stage does not expect is held not-ready. When the stage is full and its output is taken, it can accept its next item in the same cycle. The leftmost stage is the same module with `IS_LEFTMOST` set. It has no left input and tags every item it emits.

Top module: `mrg_bottom_stage`

## Requirements
- R1: During and directly after reset, out_valid is 0, up_ready is 1 and left_ready is 0.
- R2: The first item accepted after reset is taken from the up port.
- R3: After an item with out_tag = 1 is emitted, the next item accepted is taken from the up port.
- R4: After an item with out_tag = 0 is emitted, the next item accepted is taken from the left port (when IS_LEFTMOST = 0).
- R5: Only the expected port is ever ready, so up_ready and left_ready are never 1 together. While the stage is full, neither is 1 unless out_ready is 1.
- R6: An item taken from the up port is emitted with out_tag = 0 (IS_LEFTMOST = 0). An item taken from the left port is emitted with out_tag equal to the left_tag it arrived with.
- R7: out_data equals the data of the accepted item. While out_valid = 1 and out_ready = 0, out_valid, out_data and out_tag stay unchanged.
- R8: When the stage is full and out_ready = 1, the held item leaves in that cycle. If the port expected next is valid in the same cycle, its item is accepted in that cycle, with no empty cycle in between.
- R9: With IS_LEFTMOST = 1, left_ready is always 0 and every emitted item has out_tag = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Item offered from the column above |
| up_ready | output | 1 | Stage takes the item from above this cycle |
| up_data | input | DATA_W | Data from above |
| left_valid | input | 1 | Item offered from the left neighbour |
| left_ready | output | 1 | Stage takes the item from the left this cycle |
| left_data | input | DATA_W | Data from the left |
| left_tag | input | 1 | 1 when the left item started in the leftmost stage |
| out_valid | output | 1 | Stage holds an item for the right neighbour |
| out_ready | input | 1 | Right neighbour takes the item this cycle |
| out_data | output | DATA_W | Held data |
| out_tag | output | 1 | Origin tag of the held item |

## Verification
Two events can happen in the same cycle: the held item leaving and the next item arriving. When that happens, the item that leaves decides which port may supply the one that arrives. The bench provokes this by raising out_ready at random while random valids are offered on both ports. Its cycle-level model then checks that the ready of the right port appears together with out_ready, and that the new item is held on the next clock. It also counts such overlapping cycles and requires that some occurred. Long stretches with out_ready held low show that the held item stays stable and that both inputs remain blocked.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    typedef enum logic [1:0] {
        ST_E0 = 2'd0,   // empty, next item from above
        ST_F0 = 2'd1,   // full, untagged item
        ST_E1 = 2'd2,   // empty, next item from the left
        ST_F1 = 2'd3    // full, tagged item
    } mrg_state_t;

    typedef struct packed {
        mrg_state_t state;
    } mrg_ctrl_t;
endpackage

// File: rtl/mrg_port_sel.sv
module mrg_port_sel
    import mrg_pkg::*;
#(
    parameter bit IS_LEFTMOST = 1'b0
) (
    input  mrg_state_t state_q,
    input  logic       out_ready,
    output logic       up_ready,
    output logic       left_ready
);
    logic full_go;

    always_comb begin
        full_go = out_ready && (state_q == ST_F0 || state_q == ST_F1);
    end

    generate
        if (IS_LEFTMOST) begin : g_lm
            always_comb begin
                up_ready   = (state_q == ST_E0) || (state_q == ST_E1) || full_go;
                left_ready = 1'b0;
            end
        end else begin : g_mid
            always_comb begin
                up_ready   = (state_q == ST_E0) || (full_go && state_q == ST_F1);
                left_ready = (state_q == ST_E1) || (full_go && state_q == ST_F0);
            end
        end
    endgenerate

    always_comb begin
        AST_READY_EXCL: assert (!(up_ready && left_ready)); // R5
    end
endmodule

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
    import mrg_pkg::*;
#(
    parameter bit IS_LEFTMOST = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_fire,
    input  logic       left_fire,
    input  logic       left_tag,
    input  logic       out_fire,
    output mrg_state_t state_q,
    output logic       full,
    output logic       tag
);
    mrg_ctrl_t ctl_d, ctl_q;
    mrg_state_t load_st;

    always_comb begin
        load_st = ST_F0;
        if (up_fire) begin
            load_st = IS_LEFTMOST ? ST_F1 : ST_F0;
        end else if (left_fire) begin
            load_st = left_tag ? ST_F1 : ST_F0;
        end

        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_E0: if (up_fire) ctl_d.state = load_st;
            ST_E1: if (left_fire || up_fire) ctl_d.state = load_st;
            ST_F0: if (out_fire) ctl_d.state = (left_fire || up_fire) ? load_st
                                               : (IS_LEFTMOST ? ST_E0 : ST_E1);
            ST_F1: if (out_fire) ctl_d.state = up_fire ? load_st : ST_E0;
            default: ctl_d.state = ST_E0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q.state <= ST_E0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        state_q = ctl_q.state;
        full    = (ctl_q.state == ST_F0) || (ctl_q.state == ST_F1);
        tag     = (ctl_q.state == ST_F1);
    end

    AST_UP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        up_fire |=> full && (tag == IS_LEFTMOST)); // R6
    AST_LEFT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        left_fire |=> full && (tag == $past(left_tag))); // R6
    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full && !out_fire |=> full && $stable(tag)); // R7
endmodule

// File: rtl/mrg_hold.sv
module mrg_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_fire,
    input  logic              left_fire,
    input  logic [DATA_W-1:0] up_data,
    input  logic [DATA_W-1:0] left_data,
    input  logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (up_fire)        data_d = up_data;
        else if (left_fire) data_d = left_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign out_data = data_q;

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data)); // R7
endmodule

// File: rtl/mrg_bottom_stage.sv
module mrg_bottom_stage
    import mrg_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter bit IS_LEFTMOST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic              left_valid,
    output logic              left_ready,
    input  logic [DATA_W-1:0] left_data,
    input  logic              left_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_tag
);
    mrg_state_t state_q;
    logic up_fire, left_fire, out_fire, full, tag;

    mrg_port_sel #(.IS_LEFTMOST(IS_LEFTMOST)) u_sel (
        .state_q(state_q), .out_ready(out_ready),
        .up_ready(up_ready), .left_ready(left_ready)
    );

    assign up_fire   = up_valid && up_ready;
    assign left_fire = left_valid && left_ready;
    assign out_fire  = full && out_ready;

    mrg_ctrl #(.IS_LEFTMOST(IS_LEFTMOST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .up_fire(up_fire), .left_fire(left_fire),
        .left_tag(left_tag), .out_fire(out_fire),
        .state_q(state_q), .full(full), .tag(tag)
    );

    mrg_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .up_fire(up_fire), .left_fire(left_fire),
        .up_data(up_data), .left_data(left_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    assign out_valid = full;
    assign out_tag   = tag;

    AST_AFTER_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && out_tag && !up_fire |=> up_ready && !left_ready); // R3
    AST_AFTER_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && !out_tag && !left_fire && !IS_LEFTMOST |=> left_ready && !up_ready); // R4
    AST_FULL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !up_ready && !left_ready); // R5
    AST_LM_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        IS_LEFTMOST && out_valid |-> out_tag && !left_ready); // R9
endmodule

// File: tb/mrg_bottom_stage_bench.sv
module mrg_bottom_stage_bench;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 0, left_valid = 0, left_tag = 0, out_ready = 0;
    logic [DW-1:0] up_data = '0, left_data = '0;
    logic up_ready, left_ready, out_valid, out_tag;
    logic [DW-1:0] out_data;
    logic lm_up_ready, lm_left_ready, lm_out_valid, lm_out_tag;
    logic [DW-1:0] lm_out_data;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mrg_bottom_stage #(.DATA_W(DW), .IS_LEFTMOST(1'b0)) u_mrg_bottom_stage (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .left_valid(left_valid), .left_ready(left_ready), .left_data(left_data),
        .left_tag(left_tag), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag)
    );

    mrg_bottom_stage #(.DATA_W(DW), .IS_LEFTMOST(1'b1)) u_mrg_bottom_stage_lm (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(lm_up_ready), .up_data(up_data),
        .left_valid(left_valid), .left_ready(lm_left_ready), .left_data(left_data),
        .left_tag(left_tag), .out_valid(lm_out_valid), .out_ready(out_ready),
        .out_data(lm_out_data), .out_tag(lm_out_tag)
    );

    // behavioural model
    bit m_full = 0, m_tag = 0, m_next_left = 0, m_first = 1, m_last_tag = 0;
    logic [DW-1:0] m_data = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    task automatic one_cycle(input int pu, input int pl, input int po);
        bit e_up, e_left, uf, lf, of;
        string rreq;
        up_valid   = ($urandom_range(99) < pu);
        left_valid = ($urandom_range(99) < pl);
        left_tag   = $urandom_range(1);
        up_data    = DW'($urandom);
        left_data  = DW'($urandom);
        out_ready  = ($urandom_range(99) < po);
        #1;
        if (m_full) begin
            e_up   = out_ready && m_tag;
            e_left = out_ready && !m_tag;
        end else begin
            e_up   = !m_next_left;
            e_left = m_next_left;
        end
        rreq = m_first ? "R2" : (m_last_tag ? "R3" : "R4");
        check(rreq, {31'd0, up_ready}, {31'd0, e_up});
        check(rreq, {31'd0, left_ready}, {31'd0, e_left});
        check("R5", {31'd0, up_ready && left_ready}, 32'd0);
        check("R7", {31'd0, out_valid}, {31'd0, m_full});
        if (m_full) begin
            check("R7", {24'd0, out_data}, {24'd0, m_data});
            check("R6", {31'd0, out_tag}, {31'd0, m_tag});
        end
        check("R9", {31'd0, lm_left_ready}, 32'd0);
        if (lm_out_valid) check("R9", {31'd0, lm_out_tag}, 32'd1);
        of = m_full && out_ready;
        uf = up_valid && e_up;
        lf = left_valid && e_left;
        if (of && (uf || lf)) overlap++;
        @(posedge clk);
        if (of) begin
            m_full = 0;
            m_next_left = !m_tag;
            m_last_tag = m_tag;
        end
        if (uf) begin
            m_full = 1; m_tag = 0; m_data = up_data; m_first = 0;
        end
        if (lf) begin
            m_full = 1; m_tag = left_tag; m_data = left_data; m_first = 0;
        end
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {31'd0, up_ready}, 32'd1);
        check("R1", {31'd0, left_ready}, 32'd0);
        rst_n = 1;
        #1;
        check("R1", {31'd0, up_ready}, 32'd1);
        check("R1", {31'd0, left_ready}, 32'd0);
        // first acceptance must come from above even with left busy
        for (int i = 0; i < 4; i++) one_cycle(0, 100, 0);
        check("R2", {31'd0, out_valid}, 32'd0);
        for (int i = 0; i < 1500; i++) one_cycle(70, 70, 60);
        for (int i = 0; i < 800; i++)  one_cycle(20, 25, 90);
        for (int i = 0; i < 400; i++)  one_cycle(90, 90, 5);
        for (int i = 0; i < 800; i++)  one_cycle(100, 100, 100);
        check("R8", {31'd0, overlap > 0}, 32'd1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule